// File: doc/BRIEF.md
# Write Queue and Bus Direction Arbiter

This block sits in front of a memory channel whose single data path carries both reads and writes, so the path has a direction that must be turned around before traffic of the other kind can use it. Reads go straight through to the output while the path faces the read side. Writes are parked in an in-order queue and are not sent one at a time. Once enough writes have built up, the arbiter turns the path around and sends a burst of them. It then turns back to reads.

A burst starts when the queue holds `HIGH` entries and ends once it has shrunk to `LOW` entries. The gap between the two levels groups writes into bursts, so the turnaround cost is paid once per burst instead of once per write. Each turnaround leaves the output idle for `TURN` cycles. Reads wait, back-pressured, while a burst and its turnarounds are in progress.

All three streams use valid/ready. A transfer happens on a rising edge where both valid and ready are high. A source that raises valid must hold it and its payload until the transfer. The output holds its valid and payload steady while `out_ready` is low. `wr_in_ready` is low only when the queue is full. `rd_in_ready` is high only while the path faces reads and the sink is ready.

Top module: `wq_drain_arb`

## Requirements
- R1: In read mode a pending read is offered at the output in the same cycle: `out_valid` equals `rd_in_valid`, `out_addr` equals `rd_in_addr`, `out_is_wr` is 0, and `rd_in_ready` equals `out_ready`.
- R2: When the output changes direction, at least `TURN` idle cycles separate the last transfer of one kind from the first transfer of the other. The gap is exactly `TURN` when the new side has traffic waiting and `out_ready` stays high.
- R3: When a read transfers in a cycle where occupancy is at least `HIGH`, the next cycle carries no read transfer.
- R4: A write is offered only while occupancy is above `LOW`. Once a burst starts it continues until occupancy is `LOW`. With no new writes arriving, a burst is exactly `HIGH-LOW` writes.
- R5: While a write is offered, `rd_in_ready` is 0.
- R6: `wr_in_ready` is 1 exactly when occupancy is below `DEPTH`. Occupancy counts writes accepted and not yet sent. A write offered while the queue is full is not taken.
- R7: Writes leave in the order they were accepted, with address and data unchanged, marked by `out_is_wr` = 1.
- R8: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 and `out_addr`, `out_data` and `out_is_wr` unchanged.
- R9: After reset the block is in read mode with an empty queue. With no read pending, `out_valid` is 0, `out_is_wr` is 0 and `wr_in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_in_valid | input | 1 | Read request valid |
| rd_in_ready | output | 1 | Read request accepted this cycle when high with valid |
| rd_in_addr | input | AW | Read address |
| wr_in_valid | input | 1 | Write request valid |
| wr_in_ready | output | 1 | Queue has space |
| wr_in_addr | input | AW | Write address |
| wr_in_data | input | DW | Write data |
| out_valid | output | 1 | Output transfer valid |
| out_ready | input | 1 | Downstream can take a transfer |
| out_is_wr | output | 1 | 1 for a write, 0 for a read |
| out_addr | output | AW | Transfer address |
| out_data | output | DW | Write data; 0 for reads |

## Verification
A read is due at the output in the same cycle it is presented. An accepted write changes occupancy, and so `wr_in_ready` and the start of a burst, one edge later. The first write of a burst appears `TURN` cycles after the last read, and reads resume `TURN` cycles after the last write of the burst. The bench changes inputs just after each rising edge and samples at the falling edge, so every same-cycle result is read in its own cycle. A bench model of occupancy, advanced per observed handshake, gives the expected `wr_in_ready`, write order and burst ends. Idle gaps between transfers are counted in cycles and compared with `TURN`.

// File: rtl/wq_drain_pkg.sv
package wq_drain_pkg;
  typedef enum logic [1:0] {
    MODE_RD    = 2'd0,
    MODE_TO_WR = 2'd1,
    MODE_WR    = 2'd2,
    MODE_TO_RD = 2'd3
  } bus_mode_e;
endpackage

// File: rtl/wq_fifo.sv
module wq_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 48,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_word,
  input  logic          pop,
  output logic [W-1:0]  head_word,
  output logic [CW-1:0] fill
);
  logic [W-1:0]  slot [DEPTH];
  logic [PW-1:0] wptr, rptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && wptr == PW'(i)) slot[i] <= push_word;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      case ({push, pop})
        2'b10:   fill <= fill + CW'(1);
        2'b01:   fill <= fill - CW'(1);
        default: fill <= fill;
      endcase
    end
  end

  assign head_word = slot[rptr];
endmodule

// File: rtl/wq_dir_ctrl.sv
module wq_dir_ctrl
  import wq_drain_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int HIGH  = 6,
  parameter int LOW   = 2,
  parameter int TURN  = 3,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int TW   = (TURN > 1) ? $clog2(TURN) : 1,
  localparam int TLOAD = (TURN > 0) ? TURN - 1 : 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] fill,
  input  logic          rd_pending,
  input  logic          sink_ready,
  input  logic          wr_pop,
  output bus_mode_e     mode
);
  bus_mode_e     mode_n;
  logic [TW-1:0] tcnt, tcnt_n;
  logic          start_drain, end_drain;

  // a stalled read keeps the path until it transfers
  assign start_drain = (fill >= CW'(HIGH)) && !(rd_pending && !sink_ready);
  // leave on the pop that brings occupancy down to the low level
  assign end_drain   = wr_pop && (fill <= CW'(LOW + 1));

  always_comb begin
    mode_n = mode;
    tcnt_n = tcnt;
    unique case (mode)
      MODE_RD: if (start_drain) begin
        mode_n = (TURN == 0) ? MODE_WR : MODE_TO_WR;
        tcnt_n = TW'(TLOAD);
      end
      MODE_TO_WR: begin
        if (tcnt == '0) mode_n = MODE_WR;
        else            tcnt_n = tcnt - TW'(1);
      end
      MODE_WR: if (end_drain) begin
        mode_n = (TURN == 0) ? MODE_RD : MODE_TO_RD;
        tcnt_n = TW'(TLOAD);
      end
      MODE_TO_RD: begin
        if (tcnt == '0) mode_n = MODE_RD;
        else            tcnt_n = tcnt - TW'(1);
      end
      default: mode_n = MODE_RD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= MODE_RD;
      tcnt <= '0;
    end else begin
      mode <= mode_n;
      tcnt <= tcnt_n;
    end
  end
endmodule

// File: rtl/wq_drain_arb.sv
module wq_drain_arb
  import wq_drain_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int HIGH  = 6,
  parameter int LOW   = 2,
  parameter int TURN  = 3,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int EW   = AW + DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_in_valid,
  output logic          rd_in_ready,
  input  logic [AW-1:0] rd_in_addr,
  input  logic          wr_in_valid,
  output logic          wr_in_ready,
  input  logic [AW-1:0] wr_in_addr,
  input  logic [DW-1:0] wr_in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_is_wr,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_data
);
  bus_mode_e     mode;
  logic [CW-1:0] fill;
  logic [EW-1:0] head;
  logic          push, pop, wr_offer;

  assign wr_in_ready = fill < CW'(DEPTH);
  assign push        = wr_in_valid && wr_in_ready;
  assign wr_offer    = (mode == MODE_WR) && (fill > CW'(LOW));
  assign pop         = wr_offer && out_ready;

  wq_fifo #(.DEPTH(DEPTH), .W(EW)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_word ({wr_in_addr, wr_in_data}),
    .pop       (pop),
    .head_word (head),
    .fill      (fill)
  );

  wq_dir_ctrl #(.DEPTH(DEPTH), .HIGH(HIGH), .LOW(LOW), .TURN(TURN)) u_dir (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill       (fill),
    .rd_pending (rd_in_valid),
    .sink_ready (out_ready),
    .wr_pop     (pop),
    .mode       (mode)
  );

  always_comb begin
    rd_in_ready = 1'b0;
    out_valid   = 1'b0;
    out_is_wr   = 1'b0;
    out_addr    = rd_in_addr;
    out_data    = '0;
    if (mode == MODE_RD) begin
      rd_in_ready = out_ready;
      out_valid   = rd_in_valid;
    end else if (mode == MODE_WR) begin
      out_valid = wr_offer;
      out_is_wr = 1'b1;
      out_addr  = head[EW-1:DW];
      out_data  = head[DW-1:0];
    end
  end
endmodule

// File: rtl/wq_drain_arb_chk.sv
module wq_drain_arb_chk #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int LOW   = 2,
  parameter int TURN  = 3,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int GW   = $clog2(TURN + 2)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_in_valid,
  input logic          rd_in_ready,
  input logic [AW-1:0] rd_in_addr,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_is_wr,
  input logic [AW-1:0] out_addr,
  input logic [DW-1:0] out_data,
  input logic [CW-1:0] fill
);
  logic          xfer, seen, last_wr;
  logic [GW-1:0] gap;

  assign xfer = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen    <= 1'b0;
      last_wr <= 1'b0;
      gap     <= '0;
    end else if (xfer) begin
      seen    <= 1'b1;
      last_wr <= out_is_wr;
      gap     <= '0;
    end else if (gap < GW'(TURN)) begin
      gap <= gap + GW'(1);
    end
  end

  AST_RD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_is_wr |-> rd_in_valid && out_addr == rd_in_addr && rd_in_ready == out_ready); // R1
  AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && seen && (out_is_wr != last_wr) |-> gap >= GW'(TURN)); // R2
  AST_WR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_is_wr |-> fill > CW'(LOW)); // R4
  AST_RD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_is_wr |-> !rd_in_ready); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH)); // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && out_is_wr |=> out_valid && out_is_wr && $stable(out_addr) && $stable(out_data)); // R8
endmodule

bind wq_drain_arb wq_drain_arb_chk #(
  .AW(AW), .DW(DW), .DEPTH(DEPTH), .LOW(LOW), .TURN(TURN)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_in_valid (rd_in_valid),
  .rd_in_ready (rd_in_ready),
  .rd_in_addr  (rd_in_addr),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_is_wr   (out_is_wr),
  .out_addr    (out_addr),
  .out_data    (out_data),
  .fill        (fill)
);

// File: tb/wq_drain_arb_test.sv
module wq_drain_arb_test;
  localparam int AW = 16, DW = 32, DEPTH = 8, HIGH = 6, LOW = 2, TURN = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_v = 1'b0, wr_v = 1'b0, o_rdy = 1'b0;
  logic [AW-1:0] rd_a = '0, wr_a = '0;
  logic [DW-1:0] wr_d = '0;
  logic rd_in_ready, wr_in_ready, out_valid, out_is_wr;
  logic [AW-1:0] out_addr;
  logic [DW-1:0] out_data;

  always #5 clk = ~clk;

  wq_drain_arb #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .HIGH(HIGH), .LOW(LOW), .TURN(TURN)) uut (
    .clk(clk), .rst_n(rst_n),
    .rd_in_valid(rd_v), .rd_in_ready(rd_in_ready), .rd_in_addr(rd_a),
    .wr_in_valid(wr_v), .wr_in_ready(wr_in_ready), .wr_in_addr(wr_a), .wr_in_data(wr_d),
    .out_valid(out_valid), .out_ready(o_rdy), .out_is_wr(out_is_wr),
    .out_addr(out_addr), .out_data(out_data)
  );

  int total = 0, bad = 0;
  bit done = 0;
  logic [AW+DW-1:0] exp_q[$];
  int p_rd, p_wr, p_rdy, wr_cap, pushes;
  bit rd_acc, wr_acc;
  bit had, last_dir, prev_stall, rd_hi_flag;
  int idle, burst, last_burst, gap_to_wr, gap_to_rd;
  logic prev_wr;
  logic [AW-1:0] prev_addr;
  logic [DW-1:0] prev_data;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit can_push();
    return exp_q.size() < DEPTH;
  endfunction

  task automatic sample();
    bit dir;
    rd_acc = 0;
    wr_acc = 0;
    if (prev_stall) // R8
      check(out_valid && out_is_wr == prev_wr && out_addr == prev_addr && out_data == prev_data,
            "R8", {out_is_wr, out_addr}, {prev_wr, prev_addr});
    check(wr_in_ready == can_push(), "R6", wr_in_ready, can_push());
    if (out_valid && out_is_wr) check(!rd_in_ready, "R5", rd_in_ready, 0);
    if (out_valid && !out_is_wr)
      check(rd_v && out_addr == rd_a && rd_in_ready == o_rdy, "R1", out_addr, rd_a);
    if (out_valid && o_rdy) begin
      dir = out_is_wr;
      if (rd_hi_flag) check(dir, "R3", dir, 1);
      rd_hi_flag = !dir && (exp_q.size() >= HIGH);
      if (dir) begin
        check(exp_q.size() > LOW, "R4", exp_q.size(), LOW + 1);
        if (exp_q.size() > 0) begin
          check({out_addr, out_data} == exp_q[0], "R7", {out_addr, out_data}, exp_q[0]);
          void'(exp_q.pop_front());
        end else check(0, "R7", 0, 1);
      end else rd_acc = 1;
      if (had && dir != last_dir) begin
        check(idle >= TURN, "R2", idle, TURN);
        if (dir) gap_to_wr = idle;
        else begin
          gap_to_rd = idle;
          last_burst = burst;
          burst = 0;
        end
      end
      if (dir) burst++;
      idle = 0;
      last_dir = dir;
      had = 1;
    end else begin
      rd_hi_flag = 0;
      idle++;
    end
    prev_stall = out_valid && !o_rdy;
    prev_wr = out_is_wr;
    prev_addr = out_addr;
    prev_data = out_data;
    if (wr_v && wr_in_ready) begin
      exp_q.push_back({wr_a, wr_d});
      wr_acc = 1;
      pushes++;
    end
  endtask

  task automatic drive();
    if (!rd_v || rd_acc) begin
      rd_v = ($urandom % 100) < p_rd;
      rd_a = AW'($urandom);
    end
    if (!wr_v || wr_acc) begin
      wr_v = (($urandom % 100) < p_wr) && (wr_cap < 0 || pushes < wr_cap);
      wr_a = AW'($urandom);
      wr_d = $urandom;
    end
    o_rdy = ($urandom % 100) < p_rdy;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sample();
      @(posedge clk);
      #1;
      drive();
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); // R9
    check(!out_valid && !out_is_wr && wr_in_ready, "R9", {out_valid, out_is_wr, wr_in_ready}, 3'b001);

    // directed: reads flowing, HIGH writes, exact gaps and burst length
    p_rd = 100; p_wr = 100; p_rdy = 100; wr_cap = HIGH; pushes = 0;
    gap_to_wr = -1; gap_to_rd = -1; last_burst = -1;
    @(posedge clk); #1 drive();
    cyc(40);
    check(gap_to_wr == TURN, "R2", gap_to_wr, TURN);
    check(gap_to_rd == TURN, "R2", gap_to_rd, TURN);
    check(last_burst == HIGH - LOW, "R4", last_burst, HIGH - LOW);
    check(exp_q.size() == LOW, "R4", exp_q.size(), LOW);

    // directed: fill to full with the sink stalled, then drain
    p_rd = 0; p_wr = 100; p_rdy = 0; wr_cap = -1;
    cyc(20);
    check(!wr_in_ready && exp_q.size() == DEPTH, "R6", wr_in_ready, 0);
    p_wr = 0; p_rdy = 100;
    cyc(30);
    check(exp_q.size() == LOW, "R4", exp_q.size(), LOW);
    check(out_valid == 0, "R4", out_valid, 0);

    // random mix
    for (int ph = 0; ph < 6; ph++) begin
      p_rd = 20 + 15 * ph; p_wr = 70 - 8 * ph; p_rdy = 50 + 10 * (ph % 4);
      cyc(1500);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule